// File: doc/BRIEF.md
# Shared Interrupt / Power-Down Pin Controller

This block owns one active-low pad that serves two purposes. Out of reset the pad is an input: the block synchronises it, and a low level there asks the PHY core to power down. This request is ORed with the core's own power-down control bit. Once software sets the output-select bit, the pad's input function is disabled and the pad becomes an active-low interrupt output.

Seven event strobes from the core are captured as sticky pending flags. A source can set its flag only when its enable bit is set. The pad is driven low while interrupts are enabled and any flag is pending, or while the test bit is set. A single read of the status register returns every pending flag and clears all of them. An event that arrives in the cycle of that read survives the clear.

Software reaches two 16-bit registers through a plain register port. Reads are combinational on the address. Writes and clear-on-read take effect at the clock edge.

Top module: `phy_irq_pin_ctrl`

## Requirements
- R1: After reset the pad is an input (`pad_oe`=0), `pad_out`=1, both registers read 0x0000, and `pd_req` equals `core_pd_bit` for as long as `pad_in` stays high.
- R2: The control register sits at address 0x11. Bit 0 selects pad output, bit 1 enables interrupts and bit 2 is the test bit. Bits 15:3 ignore writes and read 0. `pad_oe` equals bit 0 from the edge after the write.
- R3: The status register sits at address 0x12. Bits 6:0 are writable enable bits. Bit 7 reads 0. Writes to bits 15:8 have no effect on the value read back.
- R4: `irq_evt[i]` high at an edge while enable bit i is set makes pending bit 8+i read 1 after that edge. The flag stays set until a clearing read. An event whose enable bit is clear sets nothing. Sources are: 0 receive-error half-full, 1 false-carrier half-full, 2 auto-negotiation done, 3 duplex change, 4 speed change, 5 link change, 6 energy detect.
- R5: Several pending bits may be set at once. A read (`reg_rd`=1) at address 0x12 returns them all, and after that edge every pending bit reads 0.
- R6: An enabled event present in the same cycle as a clearing read is pending after that edge.
- R7: While `pad_oe`=1, `pad_out` is 0 exactly when interrupts are enabled and at least one flag is pending or the test bit is set. Otherwise `pad_out` is 1.
- R8: The test bit drives the pad low with every enable bit clear and nothing pending, but only while interrupts are enabled.
- R9: While `pad_oe`=0, `pad_in` low at two consecutive edges raises `pd_req` after the second one. While `pad_oe`=1 the pad level is ignored. `core_pd_bit`=1 always gives `pd_req`=1.
- R10: Writing 0x0003 to address 0x11 and then 0x0060 to 0x12 arms link change and energy detect, so that either one pulls the pad low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clear-on-read trigger) |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq_evt | input | 7 | Event strobes from the core |
| core_pd_bit | input | 1 | Power-down control bit from the core's basic control register |
| pad_in | input | 1 | Pad level as seen by the input buffer |
| pad_out | output | 1 | Pad output value (active-low interrupt) |
| pad_oe | output | 1 | Pad output enable |
| pd_req | output | 1 | Power-down request to the core |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never both high at address 0x12. They also assume that `irq_evt` is a synchronous strobe in the clock domain, while `pad_in` may change at any time. The stimulus drives every input on the falling clock edge and never pairs a write with a read. It changes `pad_in` only while the effect of the two-stage synchroniser can be watched at the next two rising edges.

// File: rtl/phy_irq_pkg.sv
// Package: shared constants and types for the interrupt/power-down pin block.
// Assumes a fixed layout of seven event sources in a 16-bit status register.
package phy_irq_pkg;
    localparam int unsigned NUM_SRC = 7;

    // Control register fields, bit 0 upward
    typedef struct packed {
        logic test_irq;   // bit 2
        logic irq_en;     // bit 1
        logic out_sel;    // bit 0
    } irq_ctl_t;

    localparam int unsigned CTL_W = $bits(irq_ctl_t);
endpackage

// File: rtl/irq_pending.sv
// Module: sticky pending flags, one per event source.
// Assumes evt is synchronous to clk; clr is a one-cycle clear-on-read strobe.
// An event in the clearing cycle survives the clear.
module irq_pending #(
    parameter int unsigned NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] enable,
    input  logic               clr,
    output logic [NUM_SRC-1:0] pending
);
    logic [NUM_SRC-1:0] hit;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            // Qualify the event with its enable bit
            assign hit[i] = evt[i] & enable[i];

            // Set on enabled event, clear on read unless a new hit arrives
            always_ff @(posedge clk) begin
                if (!rst_n)      pending[i] <= 1'b0;
                else if (clr)    pending[i] <= hit[i];
                else if (hit[i]) pending[i] <= 1'b1;
            end
        end
    endgenerate

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ((evt & enable) == '0)) |=> (pending == '0)); // R5

    AST_RACE_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((pending & $past(evt & enable)) == $past(evt & enable))); // R6

    AST_STICKY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && ((evt & enable) == '0)) |=> $stable(pending)); // R4
endmodule

// File: rtl/pad_in_sync.sv
// Module: multi-stage synchroniser for the asynchronous pad input.
// Assumes STAGES >= 2; resets to the idle (pulled-up) level.
module pad_in_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the pad level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_pad_drv.sv
// Module: decides pad direction and the active-low interrupt level.
// Assumes pending and ctl come from registers, so pad_out is glitch-free.
module irq_pad_drv
    import phy_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  irq_ctl_t           ctl,
    input  logic [NUM_SRC-1:0] pending,
    output logic               pad_oe,
    output logic               pad_out
);
    logic irq_cause;
    logic irq_active;

    // Any pending flag or the test bit is a cause
    assign irq_cause  = (|pending) | ctl.test_irq;
    // Only an enabled output pad carries the interrupt
    assign irq_active = ctl.out_sel & ctl.irq_en & irq_cause;
    assign pad_oe     = ctl.out_sel;
    assign pad_out    = ~irq_active;

    AST_PAD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && !ctl.irq_en) |-> pad_out); // R7

    AST_PAD_LOW_ON_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && ctl.irq_en && (pending != '0)) |-> !pad_out); // R7
endmodule

// File: rtl/phy_irq_pin_ctrl.sv
// Module: top of the shared interrupt / power-down pin controller.
// Holds the control and enable registers, the read mux and the power-down OR.
// Assumes reg_wr and reg_rd are never both asserted for the status address.
module phy_irq_pin_ctrl
    import phy_irq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned DATA_W      = 16,
    parameter logic [4:0]  CTL_ADDR    = 5'h11,
    parameter logic [4:0]  STS_ADDR    = 5'h12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] irq_evt,
    input  logic               core_pd_bit,
    input  logic               pad_in,
    output logic               pad_out,
    output logic               pad_oe,
    output logic               pd_req
);
    localparam int unsigned HALF = DATA_W / 2;

    irq_ctl_t           ctl_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] pending;
    logic               sel_ctl, sel_sts;
    logic               clr_rd;
    logic               pad_sync;
    logic               unused_wdata;

    assign sel_ctl      = (reg_addr == ADDR_W'(CTL_ADDR));
    assign sel_sts      = (reg_addr == ADDR_W'(STS_ADDR));
    assign clr_rd       = reg_rd & sel_sts;
    assign unused_wdata = ^reg_wdata[DATA_W-1:CTL_W];

    // Control register write
    always_ff @(posedge clk) begin
        if (!rst_n)             ctl_q <= '0;
        else if (reg_wr && sel_ctl) ctl_q <= irq_ctl_t'(reg_wdata[CTL_W-1:0]);
    end

    // Enable bits in the low byte of the status register
    always_ff @(posedge clk) begin
        if (!rst_n)             enable_q <= '0;
        else if (reg_wr && sel_sts) enable_q <= reg_wdata[NUM_SRC-1:0];
    end

    // Pending flag capture with clear-on-read
    irq_pending #(.NUM_SRC(NUM_SRC)) i_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (irq_evt),
        .enable  (enable_q),
        .clr     (clr_rd),
        .pending (pending)
    );

    // Pad direction and interrupt level
    irq_pad_drv #(.NUM_SRC(NUM_SRC)) i_pad_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl_q),
        .pending (pending),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    // Bring the asynchronous pad level into the clock domain
    pad_in_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    // Power-down: core bit ORed with the low pad while the pad is an input
    assign pd_req = core_pd_bit | (~ctl_q.out_sel & ~pad_sync);

    // Read mux, combinational on the address
    always_comb begin
        reg_rdata = '0;
        if (sel_ctl) begin
            reg_rdata[CTL_W-1:0] = ctl_q;
        end else if (sel_sts) begin
            reg_rdata[NUM_SRC-1:0]        = enable_q;
            reg_rdata[HALF+NUM_SRC-1:HALF] = pending;
        end
    end

    AST_CTL_WRITE_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_ctl) |=> (pad_oe == $past(reg_wdata[0]))); // R2

    AST_RSV_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sel_sts |-> (!reg_rdata[DATA_W-1] && !reg_rdata[HALF-1])); // R3

    AST_PD_INPUT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && !core_pd_bit) |-> !pd_req); // R9

    AST_PD_CORE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        core_pd_bit |-> pd_req); // R9
endmodule

// File: tb/test_phy_irq_pin_ctrl.sv
`timescale 1ns/1ps
module test_phy_irq_pin_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [6:0]  irq_evt = '0;
    logic        core_pd_bit = 1'b0;
    logic        pad_in = 1'b1;
    logic        pad_out, pad_oe, pd_req;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    phy_irq_pin_ctrl i_phy_irq_pin_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_evt(irq_evt), .core_pd_bit(core_pd_bit), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pd_req(pd_req)
    );

    // Row: {wr, rd, addr, wdata, evt, expected rdata, expected pad_out, expected pad_oe}
    // Expectations hold at the check point, before the row's rising edge.
    localparam int NV = 29;
    localparam logic [47:0] VEC [NV] = '{
        {1'b0,1'b1,5'h11,16'h0000,7'h00,16'h0000,1'b1,1'b0}, // 0
        {1'b1,1'b0,5'h11,16'h0003,7'h00,16'h0000,1'b1,1'b0}, // 1
        {1'b1,1'b0,5'h12,16'h0060,7'h00,16'h0000,1'b1,1'b1}, // 2
        {1'b0,1'b1,5'h11,16'h0000,7'h00,16'h0003,1'b1,1'b1}, // 3
        {1'b0,1'b0,5'h12,16'h0000,7'h01,16'h0060,1'b1,1'b1}, // 4
        {1'b0,1'b0,5'h12,16'h0000,7'h00,16'h0060,1'b1,1'b1}, // 5
        {1'b0,1'b0,5'h12,16'h0000,7'h20,16'h0060,1'b1,1'b1}, // 6
        {1'b0,1'b0,5'h12,16'h0000,7'h00,16'h2060,1'b0,1'b1}, // 7
        {1'b0,1'b0,5'h12,16'h0000,7'h40,16'h2060,1'b0,1'b1}, // 8
        {1'b0,1'b1,5'h12,16'h0000,7'h00,16'h6060,1'b0,1'b1}, // 9
        {1'b0,1'b0,5'h12,16'h0000,7'h00,16'h0060,1'b1,1'b1}, // 10
        {1'b1,1'b0,5'h12,16'h007F,7'h00,16'h0060,1'b1,1'b1}, // 11
        {1'b0,1'b0,5'h12,16'h0000,7'h7F,16'h007F,1'b1,1'b1}, // 12
        {1'b0,1'b0,5'h12,16'h0000,7'h00,16'h7F7F,1'b0,1'b1}, // 13
        {1'b0,1'b1,5'h12,16'h0000,7'h04,16'h7F7F,1'b0,1'b1}, // 14
        {1'b0,1'b0,5'h12,16'h0000,7'h00,16'h047F,1'b0,1'b1}, // 15
        {1'b0,1'b1,5'h12,16'h0000,7'h00,16'h047F,1'b0,1'b1}, // 16
        {1'b0,1'b0,5'h12,16'h0000,7'h00,16'h007F,1'b1,1'b1}, // 17
        {1'b1,1'b0,5'h12,16'hFFFF,7'h00,16'h007F,1'b1,1'b1}, // 18
        {1'b0,1'b0,5'h12,16'h0000,7'h00,16'h007F,1'b1,1'b1}, // 19
        {1'b1,1'b0,5'h11,16'hFFFF,7'h00,16'h0003,1'b1,1'b1}, // 20
        {1'b0,1'b1,5'h11,16'h0000,7'h00,16'h0007,1'b0,1'b1}, // 21
        {1'b1,1'b0,5'h12,16'h0000,7'h00,16'h007F,1'b0,1'b1}, // 22
        {1'b0,1'b0,5'h12,16'h0000,7'h7F,16'h0000,1'b0,1'b1}, // 23
        {1'b0,1'b0,5'h12,16'h0000,7'h00,16'h0000,1'b0,1'b1}, // 24
        {1'b1,1'b0,5'h11,16'h0005,7'h00,16'h0007,1'b0,1'b1}, // 25
        {1'b0,1'b0,5'h11,16'h0000,7'h00,16'h0005,1'b1,1'b1}, // 26
        {1'b1,1'b0,5'h11,16'h0000,7'h00,16'h0005,1'b1,1'b1}, // 27
        {1'b0,1'b0,5'h11,16'h0000,7'h00,16'h0000,1'b1,1'b0}  // 28
    };

    function automatic string tag_of(int i);
        if (i <= 3)  return "R2";
        if (i <= 5)  return "R4";
        if (i <= 8)  return "R10";
        if (i <= 10) return "R5";
        if (i <= 13) return "R4";
        if (i <= 15) return "R6";
        if (i <= 17) return "R5";
        if (i <= 19) return "R3";
        if (i <= 21) return "R8";
        if (i <= 24) return "R4";
        if (i <= 26) return "R8";
        return "R7";
    endfunction

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_step();
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; irq_evt = '0;
    endtask

    task automatic wr_reg(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_rd = 1'b0; reg_addr = a; reg_wdata = d; irq_evt = '0;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Watchdog: counts as a failed check and still prints the summary
    initial begin
        #1000000;
        n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        reg_addr = 5'h11; #0.1;
        check("R1", "ctl after reset", reg_rdata, 16'h0000);
        reg_addr = 5'h12; #0.1;
        check("R1", "sts after reset", reg_rdata, 16'h0000);
        check("R1", "pad_oe/pad_out/pd_req", {13'd0, pad_oe, pad_out, pd_req}, 16'h0002);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {reg_wr, reg_rd, reg_addr, reg_wdata, irq_evt} = VEC[i][47:18];
            #1;
            check(tag_of(i), "rdata", reg_rdata, VEC[i][17:2]);
            check(tag_of(i), "pad_out", {15'd0, pad_out}, {15'd0, VEC[i][1]});
            check(tag_of(i), "pad_oe", {15'd0, pad_oe}, {15'd0, VEC[i][0]});
        end
        idle_step();

        // R7: output pad with interrupts disabled stays high although a flag is pending
        wr_reg(5'h11, 16'h0001);
        wr_reg(5'h12, 16'h0020);
        @(negedge clk); irq_evt = 7'h20;
        idle_step(); reg_addr = 5'h12; #1;
        check("R7", "pending captured", reg_rdata, 16'h2020);
        check("R7", "pad_out inten=0", {15'd0, pad_out}, 16'h0001);
        wr_reg(5'h11, 16'h0003);
        #1;
        check("R7", "pad_out inten=1", {15'd0, pad_out}, 16'h0000);

        // R9: pad ignored as output, core bit always wins
        @(negedge clk); pad_in = 1'b0;
        idle_step(); idle_step(); #1;
        check("R9", "pd_req pad output", {15'd0, pd_req}, 16'h0000);
        core_pd_bit = 1'b1; #1;
        check("R9", "pd_req core bit", {15'd0, pd_req}, 16'h0001);
        core_pd_bit = 1'b0;

        // R9: pad as input, two-stage latency
        @(negedge clk); pad_in = 1'b1;
        wr_reg(5'h11, 16'h0000);
        idle_step(); idle_step();
        @(negedge clk); pad_in = 1'b0;
        @(negedge clk); #1;
        check("R9", "pd_req after 1 edge", {15'd0, pd_req}, 16'h0000);
        @(negedge clk); #1;
        check("R9", "pd_req after 2 edges", {15'd0, pd_req}, 16'h0001);
        @(negedge clk); pad_in = 1'b1;
        @(negedge clk); @(negedge clk); #1;
        check("R9", "pd_req released", {15'd0, pd_req}, 16'h0000);

        // R1: mid-run reset clears flags and registers
        wr_reg(5'h11, 16'h0003);
        wr_reg(5'h12, 16'h0001);
        @(negedge clk); irq_evt = 7'h01;
        idle_step(); rst_n = 1'b0;
        idle_step(); rst_n = 1'b1;
        reg_addr = 5'h12; #1;
        check("R1", "sts after mid reset", reg_rdata, 16'h0000);
        check("R1", "pad after mid reset", {14'd0, pad_oe, pad_out}, 16'h0001);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule